// File: doc/BRIEF.md
# Completion-Pointer Interrupt Acknowledge Controller

This block sits between the receive and transmit queue engines and the CPU. Each time an engine finishes a buffer, it reports a completion event: a direction, a queue number and the pointer of the last descriptor it finished. The controller stores that pointer for the queue and sets the queue's pending bit. It drives a single interrupt line. That line is held back by a pacing countdown until the countdown reaches zero.

The CPU reads the status word to find out which queues need service. It then works through each such queue and acknowledges it by writing back the pointer of the last descriptor it handled. A pending bit clears only when the value written equals the pointer the hardware stored. A stale acknowledge leaves the bit set, so completions that arrive while software is busy are not lost. After servicing, software writes the pacing reload register, which restarts the countdown.

Top module: `cp_irq_ctrl`

## Requirements
- R1: After reset the status word (address 0x00), the pacing reload value (address 0x01) and the pacing count (address 0x02) all read 0, and `irq_out` is low.
- R2: A receive event with queue q (0..15) sets status bit q at the next clock edge. Its pointer becomes readable at address 0x40+q.
- R3: A transmit event with queue q (0..15) sets status bit 16+q at the next clock edge. Its pointer becomes readable at address 0x60+q.
- R4: A CPU write to address 0x40+q or 0x60+q whose data equals the stored pointer clears that queue's status bit at the next edge. A write with any other data leaves the bit set. Neither kind of write changes the stored pointer.
- R5: If a completion event and a matching acknowledge for the same queue fall in the same cycle, the status bit stays set and the new event pointer is stored.
- R6: A write to address 0x01 sets both the reload value and the pacing count to the written 16-bit value. The count then drops by one on every clock and holds at zero. The count is readable at address 0x02.
- R7: `irq_out` is high exactly when the pacing count is zero and at least one status bit is set.
- R8: Reading the status word clears no status bit.
- R9: A receive event and a transmit event in the same cycle are both recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_evt_valid | input | 1 | Receive completion event strobe |
| rx_evt_queue | input | 4 | Receive queue number |
| rx_evt_ptr | input | 32 | Receive completion pointer |
| tx_evt_valid | input | 1 | Transmit completion event strobe |
| tx_evt_queue | input | 4 | Transmit queue number |
| tx_evt_ptr | input | 32 | Transmit completion pointer |
| reg_wr_en | input | 1 | CPU register write strobe |
| reg_addr | input | 7 | CPU register word address (used for both reads and writes) |
| reg_wdata | input | 32 | CPU write data |
| reg_rdata | output | 32 | CPU read data, decoded combinationally from `reg_addr` |
| irq_out | output | 1 | Paced interrupt line |

## Verification
The interesting overlap is a hardware completion and a CPU acknowledge that target the same queue in the same cycle. The bench creates this by driving a receive event and a write to that queue's pointer address on the same falling edge. The written data matches the old stored pointer, so on its own the write would clear the bit. The result is judged at the ports: the status bit must still read set, and the pointer address must return the new event value. The bench also drives a receive and a transmit event together, and checks that a pacing reload written while bits are pending holds the line low.

// File: rtl/cp_irq_pkg.sv
// Package: shared sizes and register address map for the completion-pointer
// interrupt controller. Assumes word addressing on the CPU register port.
package cp_irq_pkg;
    localparam int NQ      = 16;             // queues per direction
    localparam int QW      = $clog2(NQ);     // queue index width
    localparam int PTR_W   = 32;             // pointer and data width
    localparam int PACE_W  = 16;             // pacing counter width
    localparam int ADDR_W  = 7;              // register address width

    localparam logic [ADDR_W-1:0] A_STATUS = 7'h00;
    localparam logic [ADDR_W-1:0] A_RELOAD = 7'h01;
    localparam logic [ADDR_W-1:0] A_COUNT  = 7'h02;
    localparam logic [ADDR_W-1:0] A_RX_CP  = 7'h40;
    localparam logic [ADDR_W-1:0] A_TX_CP  = 7'h60;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RX   = 2'd1,
        SEL_TX   = 2'd2
    } cp_sel_e;
endpackage

// File: rtl/cp_queue_bank.sv
// Module: one direction's bank of per-queue completion pointers and pending bits.
// A hardware event stores its pointer and sets the pending bit. An acknowledge
// clears the bit only when its value equals the stored pointer. When both hit
// the same queue in the same cycle, the hardware event takes priority.
// Assumes at most one event and one acknowledge per cycle.
module cp_queue_bank #(
    parameter int NQ    = 16,
    parameter int PTR_W = 32,
    localparam int QW   = $clog2(NQ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     evt_valid,
    input  logic [QW-1:0]            evt_queue,
    input  logic [PTR_W-1:0]         evt_ptr,
    input  logic                     ack_valid,
    input  logic [QW-1:0]            ack_queue,
    input  logic [PTR_W-1:0]         ack_ptr,
    output logic [NQ-1:0]            pending,
    output logic [NQ-1:0][PTR_W-1:0] cp
);
    for (genvar i = 0; i < NQ; i++) begin : g_q
        logic hit_evt;
        logic hit_ack;

        // Purpose: decode whether this queue is addressed this cycle.
        always_comb begin
            hit_evt = evt_valid && (evt_queue == QW'(i));
            hit_ack = ack_valid && (ack_queue == QW'(i)) && (ack_ptr == cp[i]);
        end

        // Purpose: hold the pointer and pending bit; the event wins over the acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pending[i] <= 1'b0;
                cp[i]      <= '0;
            end else if (hit_evt) begin
                pending[i] <= 1'b1;
                cp[i]      <= evt_ptr;
            end else if (hit_ack) begin
                pending[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cp_pace_timer.sv
// Module: reloadable pacing down-counter. A load sets both the reload value and
// the count. The count then drops by one per clock and holds at zero.
// Assumes the load strobe lasts one cycle per write.
module cp_pace_timer #(
    parameter int PACE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PACE_W-1:0] load_val,
    output logic [PACE_W-1:0] reload_val,
    output logic [PACE_W-1:0] count,
    output logic              zero
);
    // Purpose: keep the reload value and run the countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= '0;
            count      <= '0;
        end else if (load) begin
            reload_val <= load_val;
            count      <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    // Purpose: flag an expired countdown.
    always_comb zero = (count == '0);
endmodule

// File: rtl/cp_irq_ctrl.sv
// Module: top of the completion-pointer interrupt controller. It decodes CPU
// register accesses, feeds the receive and transmit queue banks and the pacing
// timer, and forms the interrupt line. Reads are combinational from reg_addr
// and have no side effects.
module cp_irq_ctrl
    import cp_irq_pkg::*;
#(
    parameter int NQ_P   = NQ,
    parameter int PTR_WP = PTR_W,
    parameter int PACE_P = PACE_W,
    localparam int QW_L  = $clog2(NQ_P)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_evt_valid,
    input  logic [QW_L-1:0]   rx_evt_queue,
    input  logic [PTR_WP-1:0] rx_evt_ptr,
    input  logic              tx_evt_valid,
    input  logic [QW_L-1:0]   tx_evt_queue,
    input  logic [PTR_WP-1:0] tx_evt_ptr,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PTR_WP-1:0] reg_wdata,
    output logic [PTR_WP-1:0] reg_rdata,
    output logic              irq_out
);
    localparam int PEND_W = 2 * NQ_P;

    logic [NQ_P-1:0]              pend_rx, pend_tx;
    logic [NQ_P-1:0][PTR_WP-1:0]  cp_rx, cp_tx;
    logic [PEND_W-1:0]            pend_all;
    logic [PACE_P-1:0]            pace_reload, pace_cnt;
    logic                         pace_zero;
    logic                         pace_load;
    cp_sel_e                      sel;
    logic [QW_L-1:0]              q_idx;

    // Purpose: decode which queue region, if any, the address selects.
    always_comb begin
        q_idx = reg_addr[QW_L-1:0];
        if (reg_addr[ADDR_W-1:QW_L] == A_RX_CP[ADDR_W-1:QW_L])
            sel = SEL_RX;
        else if (reg_addr[ADDR_W-1:QW_L] == A_TX_CP[ADDR_W-1:QW_L])
            sel = SEL_TX;
        else
            sel = SEL_NONE;
        pace_load = reg_wr_en && (reg_addr == A_RELOAD);
    end

    cp_queue_bank #(.NQ(NQ_P), .PTR_W(PTR_WP)) u_rx_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (rx_evt_valid),
        .evt_queue (rx_evt_queue),
        .evt_ptr   (rx_evt_ptr),
        .ack_valid (reg_wr_en && (sel == SEL_RX)),
        .ack_queue (q_idx),
        .ack_ptr   (reg_wdata),
        .pending   (pend_rx),
        .cp        (cp_rx)
    );

    cp_queue_bank #(.NQ(NQ_P), .PTR_W(PTR_WP)) u_tx_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (tx_evt_valid),
        .evt_queue (tx_evt_queue),
        .evt_ptr   (tx_evt_ptr),
        .ack_valid (reg_wr_en && (sel == SEL_TX)),
        .ack_queue (q_idx),
        .ack_ptr   (reg_wdata),
        .pending   (pend_tx),
        .cp        (cp_tx)
    );

    cp_pace_timer #(.PACE_W(PACE_P)) u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pace_load),
        .load_val   (reg_wdata[PACE_P-1:0]),
        .reload_val (pace_reload),
        .count      (pace_cnt),
        .zero       (pace_zero)
    );

    // Purpose: assemble the status word and the interrupt line.
    always_comb begin
        pend_all = {pend_tx, pend_rx};
        irq_out  = pace_zero && (|pend_all);
    end

    // Purpose: select the read data; reads change no state.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_RX:   reg_rdata = cp_rx[q_idx];
            SEL_TX:   reg_rdata = cp_tx[q_idx];
            default: begin
                if (reg_addr == A_STATUS)      reg_rdata = PTR_WP'(pend_all);
                else if (reg_addr == A_RELOAD) reg_rdata = PTR_WP'(pace_reload);
                else if (reg_addr == A_COUNT)  reg_rdata = PTR_WP'(pace_cnt);
            end
        endcase
    end
endmodule

// File: rtl/cp_irq_chk.sv
// Module: assertion checker for cp_irq_ctrl, bound to every instance.
// It observes the ports plus the pending vectors, the stored pointers and the
// pacing count.
module cp_irq_chk #(
    parameter int NQ_P   = 16,
    parameter int PTR_WP = 32,
    parameter int PACE_P = 16,
    parameter int AW     = 7,
    localparam int QW_L  = $clog2(NQ_P)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rx_evt_valid,
    input logic [QW_L-1:0]             rx_evt_queue,
    input logic                        tx_evt_valid,
    input logic [QW_L-1:0]             tx_evt_queue,
    input logic                        reg_wr_en,
    input logic [AW-1:0]               reg_addr,
    input logic [PTR_WP-1:0]           reg_wdata,
    input logic [NQ_P-1:0]             pend_rx,
    input logic [NQ_P-1:0]             pend_tx,
    input logic [NQ_P-1:0][PTR_WP-1:0] cp_rx,
    input logic [PACE_P-1:0]           pace_cnt,
    input logic                        irq_out
);
    // R2
    rx_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt_valid |=> pend_rx[$past(rx_evt_queue)]);

    // R3
    tx_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt_valid |=> pend_tx[$past(tx_evt_queue)]);

    // R4
    bad_ack_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr[AW-1:QW_L] == 3'b100 && pend_rx[reg_addr[QW_L-1:0]]
         && reg_wdata != cp_rx[reg_addr[QW_L-1:0]])
        |=> pend_rx[$past(reg_addr[QW_L-1:0])]);

    // R6
    pace_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pace_cnt != '0 && !(reg_wr_en && reg_addr == 7'h01))
        |=> pace_cnt == $past(pace_cnt) - 1'b1);

    // R7
    reload_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 7'h01 && reg_wdata[PACE_P-1:0] != '0) |=> !irq_out);

    // R8
    no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> ((~{pend_tx, pend_rx}) & $past({pend_tx, pend_rx})) == '0);
endmodule

bind cp_irq_ctrl cp_irq_chk #(
    .NQ_P(NQ_P), .PTR_WP(PTR_WP), .PACE_P(PACE_P), .AW(cp_irq_pkg::ADDR_W)
) u_cp_irq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_evt_valid (rx_evt_valid),
    .rx_evt_queue (rx_evt_queue),
    .tx_evt_valid (tx_evt_valid),
    .tx_evt_queue (tx_evt_queue),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .pend_rx      (pend_rx),
    .pend_tx      (pend_tx),
    .cp_rx        (cp_rx),
    .pace_cnt     (pace_cnt),
    .irq_out      (irq_out)
);

// File: tb/test_cp_irq_ctrl.sv
// Directed bench for cp_irq_ctrl. Inputs are driven on falling edges and
// outputs are sampled one time unit after a falling edge.
module test_cp_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_evt_valid = 1'b0, tx_evt_valid = 1'b0;
    logic [3:0]  rx_evt_queue = '0, tx_evt_queue = '0;
    logic [31:0] rx_evt_ptr = '0, tx_evt_ptr = '0;
    logic        reg_wr_en = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cp_irq_ctrl i_cp_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_evt_valid(rx_evt_valid), .rx_evt_queue(rx_evt_queue), .rx_evt_ptr(rx_evt_ptr),
        .tx_evt_valid(tx_evt_valid), .tx_evt_queue(tx_evt_queue), .tx_evt_ptr(tx_evt_ptr),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1;
    endtask

    task automatic rx_evt(input logic [3:0] q, input logic [31:0] p);
        @(negedge clk);
        rx_evt_valid = 1'b1; rx_evt_queue = q; rx_evt_ptr = p;
        @(negedge clk);
        rx_evt_valid = 1'b0;
        #1;
    endtask

    task automatic tx_evt(input logic [3:0] q, input logic [31:0] p);
        @(negedge clk);
        tx_evt_valid = 1'b1; tx_evt_queue = q; tx_evt_ptr = p;
        @(negedge clk);
        tx_evt_valid = 1'b0;
        #1;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        do_reset();
        rd(7'h00, d); check("R1 status", d, 32'h0);
        rd(7'h01, d); check("R1 reload", d, 32'h0);
        rd(7'h02, d); check("R1 count", d, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_rx_tx;
        logic [31:0] d;
        do_reset();
        rx_evt(4'd5, 32'hA000_0050);
        rd(7'h00, d); check("R2 status bit5", d, 32'h0000_0020);
        rd(7'h45, d); check("R2 pointer", d, 32'hA000_0050);
        check("R7 irq with count zero", {31'b0, irq_out}, 32'h1);
        tx_evt(4'd15, 32'hB000_00F0);
        rd(7'h00, d); check("R3 status bit31", d, 32'h8000_0020);
        rd(7'h6F, d); check("R3 pointer", d, 32'hB000_00F0);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        do_reset();
        rx_evt(4'd2, 32'h0000_1234);
        wr(7'h42, 32'h0000_1230);
        rd(7'h00, d); check("R4 mismatch keeps bit", d, 32'h0000_0004);
        rd(7'h42, d); check("R4 pointer unchanged", d, 32'h0000_1234);
        wr(7'h42, 32'h0000_1234);
        rd(7'h00, d); check("R4 match clears bit", d, 32'h0);
        check("R7 irq low when none pending", {31'b0, irq_out}, 32'h0);
        tx_evt(4'd0, 32'h0000_0777);
        wr(7'h60, 32'h0000_0777);
        rd(7'h00, d); check("R4 tx match clears", d, 32'h0);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        do_reset();
        rx_evt(4'd7, 32'h0000_0100);
        @(negedge clk);
        rx_evt_valid = 1'b1; rx_evt_queue = 4'd7; rx_evt_ptr = 32'h0000_0200;
        reg_wr_en = 1'b1; reg_addr = 7'h47; reg_wdata = 32'h0000_0100;
        @(negedge clk);
        rx_evt_valid = 1'b0; reg_wr_en = 1'b0;
        #1;
        rd(7'h00, d); check("R5 bit stays set", d, 32'h0000_0080);
        rd(7'h47, d); check("R5 new pointer", d, 32'h0000_0200);
    endtask

    task automatic t_pacing;
        logic [31:0] d;
        do_reset();
        rx_evt(4'd1, 32'h10);
        wr(7'h01, 32'h0000_000A);
        rd(7'h01, d); check("R6 reload value", d, 32'h0000_000A);
        rd(7'h02, d); check("R6 count loaded", d, 32'h0000_000A);
        check("R7 irq held by pacing", {31'b0, irq_out}, 32'h0);
        for (int i = 0; i < 9; i++) @(negedge clk);
        #1;
        rd(7'h02, d); check("R6 count after 9", d, 32'h1);
        check("R7 irq still low", {31'b0, irq_out}, 32'h0);
        @(negedge clk); #1;
        rd(7'h02, d); check("R6 count at zero", d, 32'h0);
        check("R7 irq released", {31'b0, irq_out}, 32'h1);
        repeat (3) @(negedge clk);
        #1;
        rd(7'h02, d); check("R6 holds at zero", d, 32'h0);
    endtask

    task automatic t_read_dual;
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        rx_evt_valid = 1'b1; rx_evt_queue = 4'd3; rx_evt_ptr = 32'h33;
        tx_evt_valid = 1'b1; tx_evt_queue = 4'd3; tx_evt_ptr = 32'h44;
        @(negedge clk);
        rx_evt_valid = 1'b0; tx_evt_valid = 1'b0;
        #1;
        rd(7'h00, d); check("R9 both recorded", d, 32'h0008_0008);
        repeat (4) @(negedge clk);
        #1;
        rd(7'h00, d); check("R8 read keeps bits", d, 32'h0008_0008);
        rd(7'h63, d); check("R9 tx pointer", d, 32'h44);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_rx_tx();
                t_ack();
                t_collision();
                t_pacing();
                t_read_dual();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule